// File: doc/BRIEF.md
# Supply Brown-Out Filter and Reset Requester

This block is the digital half of a supply-voltage supervisor. Two synchronous comparator outputs arrive from the analog side. One says the supply sits at or below the trip level. The other says the supply has climbed above the trip level plus its hysteresis margin. The block counts consecutive low samples and raises a reset request to the chip reset controller only after a run of nine. A single sample above the hysteresis level drops the request again, so the filter is deliberately asymmetric.

Two configuration enables set the operating mode. The first powers the monitor, and nothing happens while it is low. The second permits reset generation. With only the first enable set, the block runs in polled mode: software reads an unfiltered low-supply flag from an 8-bit status/control register. The same register holds a threshold-select bit, which is driven out to the comparators to pick the trip/hysteresis pair. Changing that bit restarts the low-run count, so switching thresholds cannot cause a spurious reset.

Top module: `supply_guard`

## Requirements
- R1: `rst_req` rises at the clock edge that samples the ninth consecutive cycle with `below_trip`=1 while both enables are 1. Any sampled cycle with `below_trip`=0 restarts the run.
- R2: Once `rst_req` is 1, it stays 1 through cycles with `below_trip`=0 and `above_hyst`=0. It clears at the first edge that samples `above_hyst`=1.
- R3: While `cfg_enable`=0, `rst_req` is 0 one cycle later, the status flag reads 0, and the low-run count is discarded. After re-enabling, a full new run of nine is needed.
- R4: While `cfg_rst_en`=0, `rst_req` is 0 one cycle later and the status flag still works (polled mode).
- R5: `bus_rdata` bit 7 is the status flag and bit 5 is the threshold select. Bits 6 and 4..0 always read 0.
- R6: After reset, `bus_rdata`, `thr_sel` and `rst_req` are all 0.
- R7: When `cfg_enable`=1, bit 7 of `bus_rdata` equals `below_trip` as sampled at the previous edge. It is not delayed by the nine-cycle filter.
- R8: The low-run count saturates and does not wrap. If a long brownout runs in polled mode and `cfg_rst_en` is then set while `below_trip` stays 1, `rst_req` rises at the next edge.
- R9: A write (`bus_sel`=1, `bus_wr`=1) loads `bus_wdata` bit 5 into the threshold select, and `thr_sel` shows the new value after the edge. Other written bits have no effect. Without a write, `thr_sel` holds its value.
- R10: A write that changes the threshold select restarts the low-run count, and nine further low cycles are then needed. A write of the unchanged value does not disturb the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_enable | input | 1 | Monitor power enable |
| cfg_rst_en | input | 1 | Reset generation enable |
| below_trip | input | 1 | Comparator: supply at or below trip level |
| above_hyst | input | 1 | Comparator: supply above trip plus hysteresis |
| bus_sel | input | 1 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Status/control register contents |
| thr_sel | output | 1 | Threshold-pair select to the comparators |
| rst_req | output | 1 | Reset request to the reset controller |

## Verification
The filter is swept with low runs of every length from 1 to 14. This separates "asserts at nine" from an off-by-one at eight or ten, and each run is followed by in-band cycles and then one release cycle, which shows the hold and the single-sample release. Runs broken by a single high sample at every position from 1 to 8 show that the count restarts instead of accumulating. Long polled-mode brownouts followed by enabling resets reveal saturation against wrap. All 256 write values, each paired with alternating comparator input, pin down the register layout and show that only the select bit is writable. Writes of a changed and of an unchanged select in the middle of a run separate the restart rule from a restart on any write.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

  typedef enum logic [0:0] {
    SG_CLEAR = 1'b0,
    SG_HELD  = 1'b1
  } sg_req_state_e;

  typedef struct packed {
    logic low_flag;
    logic thr_sel;
  } sg_csr_t;

endpackage

// File: rtl/sg_rst_sync.sv
module sg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = 1'b1;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/sg_lowcount.sv
module sg_lowcount #(
  parameter int unsigned FILT_CYCLES = 9,
  localparam int unsigned CNT_W = $clog2(FILT_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic low_i,
  input  logic restart_i,
  output logic full_o
);
  localparam logic [CNT_W-1:0] LIMIT    = CNT_W'(FILT_CYCLES);
  localparam logic [CNT_W-1:0] LIMIT_M1 = CNT_W'(FILT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;
  logic             keep_run;

  assign keep_run = run_en && low_i && !restart_i;

  always_comb begin
    cnt_d = cnt_q;
    if (!keep_run)          cnt_d = '0;
    else if (cnt_q < LIMIT) cnt_d = cnt_q + 1'b1;
  end

  assign cnt_ce = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  // the current sample completes a run of FILT_CYCLES
  assign full_o = keep_run && (cnt_q >= LIMIT_M1);
endmodule

// File: rtl/sg_rstlatch.sv
module sg_rstlatch
  import supply_guard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic allow_i,
  input  logic trip_i,
  input  logic release_i,
  output logic req_o
);
  sg_req_state_e st_q;
  sg_req_state_e st_d;
  logic          st_ce;

  always_comb begin
    st_d = st_q;
    if (!allow_i) begin
      st_d = SG_CLEAR;
    end else begin
      unique case (st_q)
        SG_CLEAR: if (trip_i && !release_i) st_d = SG_HELD;
        SG_HELD:  if (release_i)            st_d = SG_CLEAR;
        default:                            st_d = SG_CLEAR;
      endcase
    end
  end

  assign st_ce = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= SG_CLEAR;
    else if (st_ce) st_q <= st_d;
  end

  assign req_o = (st_q == SG_HELD);
endmodule

// File: rtl/sg_csr.sv
module sg_csr
  import supply_guard_pkg::*;
#(
  parameter int unsigned REG_W    = 8,
  parameter int unsigned FLAG_POS = 7,
  parameter int unsigned SEL_POS  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             en_i,
  input  logic             low_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             sel_o,
  output logic             sel_change_o
);
  sg_csr_t csr_q;
  sg_csr_t csr_d;
  logic    flag_ce;
  logic    sel_ce;
  logic    sel_new;

  assign sel_new      = wdata_i[SEL_POS];
  assign sel_change_o = wr_i && (sel_new != csr_q.thr_sel);

  always_comb begin
    csr_d          = csr_q;
    csr_d.low_flag = en_i && low_i;
    if (wr_i) csr_d.thr_sel = sel_new;
  end

  assign flag_ce = (csr_d.low_flag != csr_q.low_flag);
  assign sel_ce  = wr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       csr_q.low_flag <= 1'b0;
    else if (flag_ce) csr_q.low_flag <= csr_d.low_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      csr_q.thr_sel <= 1'b0;
    else if (sel_ce) csr_q.thr_sel <= csr_d.thr_sel;
  end

  always_comb begin
    for (int i = 0; i < int'(REG_W); i++) begin
      if (i == int'(FLAG_POS))     rdata_o[i] = csr_q.low_flag;
      else if (i == int'(SEL_POS)) rdata_o[i] = csr_q.thr_sel;
      else                         rdata_o[i] = 1'b0;
    end
  end

  assign sel_o = csr_q.thr_sel;
endmodule

// File: rtl/supply_guard.sv
module supply_guard #(
  parameter int unsigned REG_W       = 8,
  parameter int unsigned FILT_CYCLES = 9,
  parameter int unsigned FLAG_POS    = 7,
  parameter int unsigned SEL_POS     = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_rst_en,
  input  logic             below_trip,
  input  logic             above_hyst,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             thr_sel,
  output logic             rst_req
);
  logic rst_sync_n;
  logic bus_write;
  logic sel_change;
  logic run_full;
  logic req_allow;

  assign bus_write = bus_sel && bus_wr;
  assign req_allow = cfg_enable && cfg_rst_en;

  sg_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst_sync (
    .clk   (clk),
    .arst_n(rst_n),
    .srst_n(rst_sync_n)
  );

  sg_csr #(
    .REG_W   (REG_W),
    .FLAG_POS(FLAG_POS),
    .SEL_POS (SEL_POS)
  ) u_csr (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_i        (bus_write),
    .wdata_i     (bus_wdata),
    .en_i        (cfg_enable),
    .low_i       (below_trip),
    .rdata_o     (bus_rdata),
    .sel_o       (thr_sel),
    .sel_change_o(sel_change)
  );

  sg_lowcount #(
    .FILT_CYCLES(FILT_CYCLES)
  ) u_lowcount (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run_en   (cfg_enable),
    .low_i    (below_trip),
    .restart_i(sel_change),
    .full_o   (run_full)
  );

  sg_rstlatch u_rstlatch (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .allow_i  (req_allow),
    .trip_i   (run_full),
    .release_i(above_hyst),
    .req_o    (rst_req)
  );
endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk #(
  parameter int unsigned REG_W       = 8,
  parameter int unsigned FILT_CYCLES = 9,
  parameter int unsigned FLAG_POS    = 7,
  parameter int unsigned SEL_POS     = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_enable,
  input logic             cfg_rst_en,
  input logic             below_trip,
  input logic             above_hyst,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [REG_W-1:0] bus_wdata,
  input logic [REG_W-1:0] bus_rdata,
  input logic             thr_sel,
  input logic             rst_req
);
  localparam int unsigned    RUN_W = $clog2(FILT_CYCLES + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(FILT_CYCLES);
  localparam logic [REG_W-1:0] LIVE_MASK =
    REG_W'((64'd1 << FLAG_POS) | (64'd1 << SEL_POS));

  logic [RUN_W-1:0] run_q;

  // independent count of enabled low samples, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         run_q <= '0;
    else if (cfg_enable && below_trip) begin
      if (run_q < RUN_MAX)              run_q <= run_q + 1'b1;
    end else                            run_q <= '0;
  end

  assert_filter_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> (run_q >= RUN_MAX));

  assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && above_hyst) |=> !rst_req);

  assert_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (!rst_req && !bus_rdata[FLAG_POS]));

  assert_polled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rst_en |=> !rst_req);

  assert_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~LIVE_MASK) == '0);

  assert_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_enable |=> (bus_rdata[FLAG_POS] == $past(below_trip)));

  assert_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr) |=> (thr_sel == $past(bus_wdata[SEL_POS])));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> $stable(thr_sel));

  assert_sel_mirror_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[SEL_POS] == thr_sel);

  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(thr_sel) |-> !$rose(rst_req));
endmodule

bind supply_guard supply_guard_chk #(
  .REG_W      (REG_W),
  .FILT_CYCLES(FILT_CYCLES),
  .FLAG_POS   (FLAG_POS),
  .SEL_POS    (SEL_POS)
) u_supply_guard_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cfg_enable(cfg_enable),
  .cfg_rst_en(cfg_rst_en),
  .below_trip(below_trip),
  .above_hyst(above_hyst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .thr_sel   (thr_sel),
  .rst_req   (rst_req)
);

// File: tb/supply_guard_bench.sv
`timescale 1ns/1ps
module supply_guard_bench;
  localparam int FILT = 9;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_enable, cfg_rst_en;
  logic       below_trip, above_hyst;
  logic       bus_sel, bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       thr_sel, rst_req;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  supply_guard u_supply_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_enable(cfg_enable),
    .cfg_rst_en(cfg_rst_en),
    .below_trip(below_trip),
    .above_hyst(above_hyst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .thr_sel   (thr_sel),
    .rst_req   (rst_req)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, sample 1 ns after the rising edge
  task automatic cyc(input logic lo, input logic hi, input logic we = 1'b0,
                     input logic [7:0] wd = 8'h00);
    @(negedge clk);
    below_trip = lo;
    above_hyst = hi;
    bus_sel    = we;
    bus_wr     = we;
    bus_wdata  = wd;
    @(posedge clk);
    #1;
  endtask

  task automatic clear_req();
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_enable = 1'b0; cfg_rst_en = 1'b0;
    below_trip = 1'b0; above_hyst = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    check("R6 rdata at reset", bus_rdata, 8'h00);
    check("R6 thr_sel at reset", {7'd0, thr_sel}, 8'd0);
    check("R6 rst_req at reset", {7'd0, rst_req}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) cyc(1'b0, 1'b0);

    // R1/R2/R7: run-length sweep in forced-reset mode
    cfg_enable = 1'b1; cfg_rst_en = 1'b1;
    for (int n = 1; n <= 14; n++) begin
      clear_req();
      for (int k = 1; k <= n; k++) begin
        cyc(1'b1, 1'b0);
        check($sformatf("R1 run n=%0d k=%0d", n, k), {7'd0, rst_req}, {7'd0, 1'(k >= FILT)});
        check("R7 flag low", {7'd0, bus_rdata[7]}, 8'd1);
      end
      for (int b = 0; b < 3; b++) begin
        cyc(1'b0, 1'b0);
        check($sformatf("R2 band hold n=%0d", n), {7'd0, rst_req}, {7'd0, 1'(n >= FILT)});
        check("R7 flag clear", {7'd0, bus_rdata[7]}, 8'd0);
      end
      cyc(1'b0, 1'b1);
      check($sformatf("R2 release n=%0d", n), {7'd0, rst_req}, 8'd0);
    end

    // R1: a single non-low sample at every position restarts the run
    for (int g = 1; g < FILT; g++) begin
      clear_req();
      for (int k = 0; k < g; k++) cyc(1'b1, 1'b0);
      cyc(1'b0, 1'b0);
      for (int k = 1; k < FILT; k++) begin
        cyc(1'b1, 1'b0);
        check($sformatf("R1 gap g=%0d k=%0d", g, k), {7'd0, rst_req}, 8'd0);
      end
      cyc(1'b1, 1'b0);
      check($sformatf("R1 gap g=%0d ninth", g), {7'd0, rst_req}, 8'd1);
    end
    clear_req();

    // R4/R8: polled mode, long brownout, then enable resets
    cfg_rst_en = 1'b0;
    for (int k = 1; k <= 20; k++) begin
      cyc(1'b1, 1'b0);
      check("R4 polled no reset", {7'd0, rst_req}, 8'd0);
      check("R4 polled flag", {7'd0, bus_rdata[7]}, 8'd1);
    end
    cfg_rst_en = 1'b1;
    cyc(1'b1, 1'b0);
    check("R8 saturated run trips at once", {7'd0, rst_req}, 8'd1);
    cfg_rst_en = 1'b0;
    cyc(1'b1, 1'b0);
    check("R4 reset enable dropped", {7'd0, rst_req}, 8'd0);
    cfg_rst_en = 1'b1;
    clear_req();

    // R3: module disabled
    cfg_enable = 1'b0;
    for (int k = 1; k <= 15; k++) begin
      cyc(1'b1, 1'b0);
      check("R3 disabled no reset", {7'd0, rst_req}, 8'd0);
      check("R3 disabled flag", {7'd0, bus_rdata[7]}, 8'd0);
    end
    cfg_enable = 1'b1;
    for (int k = 1; k <= FILT; k++) cyc(1'b1, 1'b0);
    check("R3 enabled run trips", {7'd0, rst_req}, 8'd1);
    cfg_enable = 1'b0;
    cyc(1'b1, 1'b0);
    check("R3 disable drops reset", {7'd0, rst_req}, 8'd0);
    check("R3 disable drops flag", {7'd0, bus_rdata[7]}, 8'd0);
    cfg_enable = 1'b1;
    for (int k = 1; k < FILT; k++) begin
      cyc(1'b1, 1'b0);
      check("R3 count discarded", {7'd0, rst_req}, 8'd0);
    end
    cyc(1'b1, 1'b0);
    check("R3 fresh run trips", {7'd0, rst_req}, 8'd1);
    clear_req();

    // R5/R9: every write value, polled mode
    cfg_rst_en = 1'b0;
    for (int v = 0; v < 256; v++) begin
      logic [7:0] wv;
      wv = 8'(v);
      cyc(wv[0], 1'b0, 1'b1, wv);
      check($sformatf("R5 layout v=%0h", v), bus_rdata, {wv[0], 1'b0, wv[5], 5'b0});
      check("R9 thr_sel written", {7'd0, thr_sel}, {7'd0, wv[5]});
      cyc(1'b0, 1'b0, 1'b0, ~wv);
      check("R9 no write holds", {7'd0, thr_sel}, {7'd0, wv[5]});
    end
    cfg_rst_en = 1'b1;
    clear_req();

    // R10: changed select restarts, unchanged select does not (select now 1)
    for (int k = 1; k < FILT; k++) cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b0, 1'b1, 8'h00);
    check("R10 changed select blocks trip", {7'd0, rst_req}, 8'd0);
    check("R9 select cleared", {7'd0, thr_sel}, 8'd0);
    for (int k = 1; k < FILT; k++) begin
      cyc(1'b1, 1'b0);
      check($sformatf("R10 restarted k=%0d", k), {7'd0, rst_req}, 8'd0);
    end
    cyc(1'b1, 1'b0);
    check("R10 trips after nine fresh", {7'd0, rst_req}, 8'd1);
    clear_req();
    for (int k = 1; k < FILT; k++) cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b0, 1'b1, 8'hDF);
    check("R10 same-value write keeps count", {7'd0, rst_req}, 8'd1);
    clear_req();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule